// File: doc/BRIEF.md
# Watchdog Reset and Status Controller

This block produces the chip-wide reset `rst_out` from three causes: an external hardware reset pin, a watchdog timeout and a software request. A 32-bit down-counter is reloaded by software through a kick register. When it reaches zero while the watchdog reset enable is set, the block starts a reset pulse whose width comes from a programmable stretch field. For a watchdog-caused pulse it also raises `wd_event` toward the host for the same duration.

A cause register records which source produced each reset. The resets it reports do not clear it, so software can read it after restart. Only power-on or a write-1-to-clear from software removes a bit. While the hardware pin is held, boot and configuration straps are sampled every clock. The sampled values are kept once the pin is released. Software reaches everything through a write/read strobe bus with an address and 32-bit data. Reads return data combinationally.

Top module: `rst_wdog_ctrl`

## Requirements
- R1: Writing any value to address 1 (kick) loads the counter from the reload register (address 0). A counter kicked at intervals shorter than its reload value never causes a reset.
- R2: With the enable bit set (control register address 2, bit 0), the counter decrements once per clock and stops at zero. A reset and `wd_event` start on the clock edge R+1 edges after the kick edge, where R is the reload value. R = 0 fires one edge after the kick.
- R3: With the enable bit clear, the counter still runs down to zero and reads 0 at address 1, but no reset is produced.
- R4: `wd_event` is high for exactly (F+1)×16 clocks, where F is the control field at bits 15:8. It is only ever high while `rst_out` is high.
- R5: `rst_out` rises in the same cycle the hardware pin rises, with no clock edge needed, and in the cycle a stretched pulse starts. It falls 2 clock edges after the last source goes away.
- R6: The cause register (address 3) has bit 0 for hardware pin, bit 1 for watchdog and bit 2 for software. Each cause sets its own bit, and no reset clears any bit.
- R7: Writing 1 to a cause bit clears it, writing 0 leaves it, and power-on clears all bits.
- R8: Writing control bit 1 = 1 starts a reset of (F+1)×16 clocks plus the 2-edge tail, with F taken from the same write. It sets cause bit 2 and leaves `wd_event` low.
- R9: While the hardware pin is high, the boot pins are sampled into address 4 bits 2:0 and the config pins into bits 12:8 on each clock. Once the pin is low, these values hold whatever the pins do.
- R10: Every hardware, watchdog or software reset clears the enable bit. It keeps the reload value and the stretch field.
- R11: Register writes have no effect while `rst_out` is high.
- R12: `rdata` is 0 when `rd_en` is low.
- R13: After power-on, `rst_out` is high, the cause register and enable are 0, the stretch field is 0 and the reload value is all ones.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por | input | 1 | Power-on reset, active high |
| hw_rst_in | input | 1 | External hardware reset pin, active high |
| boot_pins | input | 3 | Boot strap pins |
| cfg_pins | input | 5 | Configuration strap pins |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| addr | input | 3 | Register address |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data |
| rst_out | output | 1 | Chip reset, asynchronous assertion, synchronous release |
| wd_event | output | 1 | Watchdog event toward the host |

## Verification
The hardest state to reach from the ports is a cause register holding several causes at once, together with strap values captured under a moving pin pattern. Reaching it takes two resets in a row, each of which freezes the register bus. The bench first triggers a software reset and waits out its stretched pulse. It then holds the hardware pin while the strap pins change every clock and a write is attempted. After release, it reads the register back to confirm that both cause bits, the last strap values and the unchanged reload value are all present. The watchdog timing is swept over reload values 0 to 5 and stretch fields 0 to 2. In each run the bench counts cycles from kick to event, the event width and the release tail.

// File: rtl/rst_wdog_pkg.sv
package rst_wdog_pkg;

    localparam int ADDR_W           = 3;
    localparam int CTRL_EN_BIT      = 0;
    localparam int CTRL_SWRST_BIT   = 1;
    localparam int CTRL_STRETCH_LSB = 8;
    localparam int STRAP_CFG_LSB    = 8;
    localparam int CAUSE_W          = 3;

    typedef enum logic [ADDR_W-1:0] {
        REG_RELOAD = 3'd0,
        REG_COUNT  = 3'd1,
        REG_CTRL   = 3'd2,
        REG_CAUSE  = 3'd3,
        REG_STRAP  = 3'd4
    } reg_addr_e;

    // bit 0 hardware pin, bit 1 watchdog, bit 2 software
    typedef struct packed {
        logic sw;
        logic wd;
        logic hw;
    } cause_t;

    function automatic cause_t cause_update(cause_t cur, cause_t set_v, cause_t clr_v);
        return (cur & ~clr_v) | set_v;
    endfunction

endpackage

// File: rtl/wdog_timer.sv
module wdog_timer #(
    parameter int               CNT_W       = 32,
    parameter logic [CNT_W-1:0] RELOAD_INIT = '1
) (
    input  logic             clk,
    input  logic             por,
    input  logic             hold,
    input  logic             kick,
    input  logic             en,
    input  logic [CNT_W-1:0] reload_val,
    output logic [CNT_W-1:0] count,
    output logic             expired
);

    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (por) begin
            cnt_q <= RELOAD_INIT;
        end else if (hold || kick) begin
            cnt_q <= reload_val;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign count   = cnt_q;
    assign expired = en && (cnt_q == '0) && !hold;

endmodule

// File: rtl/pulse_stretch.sv
module pulse_stretch #(
    parameter int FIELD_W   = 8,
    parameter int UNIT_LOG2 = 4
) (
    input  logic               clk,
    input  logic               por,
    input  logic               start,
    input  logic               from_wd,
    input  logic [FIELD_W-1:0] field,
    output logic               busy,
    output logic               event_out
);

    localparam int CW = FIELD_W + UNIT_LOG2;

    logic [CW-1:0] left_q;
    logic          busy_q;
    logic          wd_q;

    always_ff @(posedge clk) begin
        if (por) begin
            left_q <= '0;
            busy_q <= 1'b0;
            wd_q   <= 1'b0;
        end else if (start && !busy_q) begin
            left_q <= {field, {UNIT_LOG2{1'b1}}};
            busy_q <= 1'b1;
            wd_q   <= from_wd;
        end else if (busy_q) begin
            if (left_q == '0) begin
                busy_q <= 1'b0;
                wd_q   <= 1'b0;
            end else begin
                left_q <= left_q - 1'b1;
            end
        end
    end

    assign busy      = busy_q;
    assign event_out = busy_q && wd_q;

endmodule

// File: rtl/rst_sync.sv
module rst_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic raw,
    output logic rst_out
);

    logic [STAGES-1:0] sh_q;

    always_ff @(posedge clk or posedge raw) begin
        if (raw) begin
            sh_q <= '1;
        end else begin
            sh_q <= {sh_q[STAGES-2:0], 1'b0};
        end
    end

    assign rst_out = sh_q[STAGES-1];

endmodule

// File: rtl/rst_wdog_regs.sv
module rst_wdog_regs
    import rst_wdog_pkg::*;
#(
    parameter int               DATA_W      = 32,
    parameter int               CNT_W       = 32,
    parameter int               FIELD_W     = 8,
    parameter int               BOOT_W      = 3,
    parameter int               CFG_W       = 5,
    parameter logic [CNT_W-1:0] RELOAD_INIT = '1
) (
    input  logic               clk,
    input  logic               por,
    input  logic               hw_rst_in,
    input  logic               in_reset,
    input  logic [BOOT_W-1:0]  boot_pins,
    input  logic [CFG_W-1:0]   cfg_pins,
    input  logic               wr_en,
    input  logic               rd_en,
    input  logic [ADDR_W-1:0]  addr,
    input  logic [DATA_W-1:0]  wdata,
    input  logic [CNT_W-1:0]   count,
    input  logic               wd_fire,
    output logic [DATA_W-1:0]  rdata,
    output logic [CNT_W-1:0]   reload_q,
    output logic               en_q,
    output cause_t             cause_q,
    output logic [BOOT_W-1:0]  boot_q,
    output logic [CFG_W-1:0]   cfg_q,
    output logic               kick,
    output logic               sw_fire,
    output logic [FIELD_W-1:0] pulse_field
);

    logic [FIELD_W-1:0] stretch_q;
    logic               wr_ok;
    reg_addr_e          wa;
    cause_t             set_v;
    cause_t             clr_v;

    assign wr_ok   = wr_en && !in_reset;
    assign wa      = reg_addr_e'(addr);
    assign kick    = wr_ok && (wa == REG_COUNT);
    assign sw_fire = wr_ok && (wa == REG_CTRL) && wdata[CTRL_SWRST_BIT];

    assign pulse_field = sw_fire ? wdata[CTRL_STRETCH_LSB +: FIELD_W] : stretch_q;

    always_comb begin
        set_v    = '0;
        set_v.hw = hw_rst_in;
        set_v.wd = wd_fire;
        set_v.sw = sw_fire;
        clr_v    = '0;
        if (wr_ok && (wa == REG_CAUSE)) begin
            clr_v = cause_t'(wdata[CAUSE_W-1:0]);
        end
    end

    always_ff @(posedge clk) begin
        if (por) begin
            reload_q  <= RELOAD_INIT;
            en_q      <= 1'b0;
            stretch_q <= '0;
            cause_q   <= '0;
            boot_q    <= '0;
            cfg_q     <= '0;
        end else begin
            if (wr_ok && (wa == REG_RELOAD)) begin
                reload_q <= wdata[CNT_W-1:0];
            end
            if (wr_ok && (wa == REG_CTRL)) begin
                en_q      <= wdata[CTRL_EN_BIT];
                stretch_q <= wdata[CTRL_STRETCH_LSB +: FIELD_W];
            end
            if (wd_fire || sw_fire || hw_rst_in) begin
                en_q <= 1'b0;
            end
            cause_q <= cause_update(cause_q, set_v, clr_v);
            if (hw_rst_in) begin
                boot_q <= boot_pins;
                cfg_q  <= cfg_pins;
            end
        end
    end

    always_comb begin
        rdata = '0;
        if (rd_en) begin
            case (wa)
                REG_RELOAD: rdata[CNT_W-1:0] = reload_q;
                REG_COUNT:  rdata[CNT_W-1:0] = count;
                REG_CTRL: begin
                    rdata[CTRL_EN_BIT]                    = en_q;
                    rdata[CTRL_STRETCH_LSB +: FIELD_W]    = stretch_q;
                end
                REG_CAUSE:  rdata[CAUSE_W-1:0] = cause_q;
                REG_STRAP: begin
                    rdata[BOOT_W-1:0]               = boot_q;
                    rdata[STRAP_CFG_LSB +: CFG_W]   = cfg_q;
                end
                default: rdata = '0;
            endcase
        end
    end

endmodule

// File: rtl/rst_wdog_ctrl.sv
module rst_wdog_ctrl
    import rst_wdog_pkg::*;
#(
    parameter int               DATA_W      = 32,
    parameter int               CNT_W       = 32,
    parameter int               FIELD_W     = 8,
    parameter int               UNIT_LOG2   = 4,
    parameter int               BOOT_W      = 3,
    parameter int               CFG_W       = 5,
    parameter int               SYNC_STAGES = 2,
    parameter logic [CNT_W-1:0] RELOAD_INIT = '1
) (
    input  logic              clk,
    input  logic              por,
    input  logic              hw_rst_in,
    input  logic [BOOT_W-1:0] boot_pins,
    input  logic [CFG_W-1:0]  cfg_pins,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    output logic              rst_out,
    output logic              wd_event
);

    logic [CNT_W-1:0]   count;
    logic [CNT_W-1:0]   reload_q;
    logic               en_q;
    cause_t             cause_q;
    logic [BOOT_W-1:0]  boot_q;
    logic [CFG_W-1:0]   cfg_q;
    logic               kick;
    logic               wd_fire;
    logic               sw_fire;
    logic [FIELD_W-1:0] pulse_field;
    logic               busy;
    logic               raw_rst;

    rst_wdog_regs #(
        .DATA_W(DATA_W), .CNT_W(CNT_W), .FIELD_W(FIELD_W),
        .BOOT_W(BOOT_W), .CFG_W(CFG_W), .RELOAD_INIT(RELOAD_INIT)
    ) u_regs (
        .clk(clk), .por(por), .hw_rst_in(hw_rst_in), .in_reset(rst_out),
        .boot_pins(boot_pins), .cfg_pins(cfg_pins),
        .wr_en(wr_en), .rd_en(rd_en), .addr(addr), .wdata(wdata),
        .count(count), .wd_fire(wd_fire), .rdata(rdata),
        .reload_q(reload_q), .en_q(en_q), .cause_q(cause_q),
        .boot_q(boot_q), .cfg_q(cfg_q), .kick(kick),
        .sw_fire(sw_fire), .pulse_field(pulse_field)
    );

    wdog_timer #(
        .CNT_W(CNT_W), .RELOAD_INIT(RELOAD_INIT)
    ) u_timer (
        .clk(clk), .por(por), .hold(rst_out), .kick(kick), .en(en_q),
        .reload_val(reload_q), .count(count), .expired(wd_fire)
    );

    pulse_stretch #(
        .FIELD_W(FIELD_W), .UNIT_LOG2(UNIT_LOG2)
    ) u_stretch (
        .clk(clk), .por(por), .start(wd_fire || sw_fire), .from_wd(wd_fire),
        .field(pulse_field), .busy(busy), .event_out(wd_event)
    );

    assign raw_rst = por || hw_rst_in || busy;

    rst_sync #(
        .STAGES(SYNC_STAGES)
    ) u_sync (
        .clk(clk), .raw(raw_rst), .rst_out(rst_out)
    );

endmodule

// File: rtl/rst_wdog_ctrl_chk.sv
module rst_wdog_ctrl_chk
    import rst_wdog_pkg::*;
#(
    parameter int CNT_W   = 32,
    parameter int BOOT_W  = 3,
    parameter int CFG_W   = 5
) (
    input logic              clk,
    input logic              por,
    input logic              hw_rst_in,
    input logic              wr_en,
    input logic [ADDR_W-1:0] addr,
    input logic              rst_out,
    input logic              wd_event,
    input logic              en_q,
    input cause_t            cause_q,
    input logic [CNT_W-1:0]  reload_q,
    input logic [BOOT_W-1:0] boot_q,
    input logic [CFG_W-1:0]  cfg_q
);

    logic [15:0] run_q;

    always_ff @(posedge clk) begin
        if (por) begin
            run_q <= '0;
        end else if (wd_event) begin
            run_q <= run_q + 1'b1;
        end else begin
            run_q <= '0;
        end
    end

    a_r4_event_within_reset: assert property (@(posedge clk) disable iff (por)
        wd_event |-> rst_out);

    a_r4_width_multiple: assert property (@(posedge clk) disable iff (por)
        $fell(wd_event) |-> (run_q[3:0] == 4'd0 && run_q != '0));

    a_r5_pin_forces_reset: assert property (@(posedge clk) disable iff (por)
        hw_rst_in |-> rst_out);

    a_r3_fire_needs_enable: assert property (@(posedge clk) disable iff (por)
        $rose(wd_event) |-> $past(en_q));

    a_r7_cause_clears_by_write: assert property (@(posedge clk) disable iff (por)
        (($past(cause_q) & ~cause_q) != '0) |-> $past(wr_en && addr == REG_CAUSE));

    a_r9_strap_holds: assert property (@(posedge clk) disable iff (por)
        !hw_rst_in |=> ($stable(boot_q) && $stable(cfg_q)));

    a_r11_reload_frozen: assert property (@(posedge clk) disable iff (por)
        rst_out |=> $stable(reload_q));

    a_r10_enable_dropped: assert property (@(posedge clk) disable iff (por)
        rst_out |=> !en_q);

endmodule

bind rst_wdog_ctrl rst_wdog_ctrl_chk #(
    .CNT_W(CNT_W), .BOOT_W(BOOT_W), .CFG_W(CFG_W)
) u_chk (
    .clk(clk), .por(por), .hw_rst_in(hw_rst_in), .wr_en(wr_en), .addr(addr),
    .rst_out(rst_out), .wd_event(wd_event), .en_q(en_q), .cause_q(cause_q),
    .reload_q(reload_q), .boot_q(boot_q), .cfg_q(cfg_q)
);

// File: tb/test_rst_wdog_ctrl.sv
module test_rst_wdog_ctrl;

    logic        clk = 1'b0;
    logic        por = 1'b1;
    logic        hw_rst_in = 1'b0;
    logic [2:0]  boot_pins = '0;
    logic [4:0]  cfg_pins = '0;
    logic        wr_en = 1'b0;
    logic        rd_en = 1'b0;
    logic [2:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic        rst_out;
    logic        wd_event;

    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    rst_wdog_ctrl i_rst_wdog_ctrl (
        .clk(clk), .por(por), .hw_rst_in(hw_rst_in), .boot_pins(boot_pins),
        .cfg_pins(cfg_pins), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
        .wdata(wdata), .rdata(rdata), .rst_out(rst_out), .wd_event(wd_event)
    );

    task automatic check_eq(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr_en = 1'b0; wdata = '0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [31:0] d);
        rd_en = 1'b1; addr = a;
        #1;
        d = rdata;
        rd_en = 1'b0;
    endtask

    // counts negedges on which rst_out stays high, starting at the current one
    task automatic reset_len(output int n);
        n = 0;
        while (rst_out && n < 10000) begin
            @(negedge clk);
            n++;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [31:0] d;
        int m;
        int w;
        int r;
        bit seen;

        // R13 power-on state
        repeat (4) @(negedge clk);
        check_eq("R13 rst_out in por", {31'd0, rst_out}, 32'd1);
        por = 1'b0;
        reset_len(r);
        check_eq("R5 release tail after por", r, 32'd2);
        rd(3'd3, d); check_eq("R13 cause", d, 32'd0);
        rd(3'd2, d); check_eq("R13 ctrl", d, 32'd0);
        rd(3'd0, d); check_eq("R13 reload", d, 32'hFFFF_FFFF);
        #1; check_eq("R12 rdata idle", rdata, 32'd0);

        // R2 R4 R5 R6 R7 R10 sweep
        for (int rv = 0; rv <= 5; rv++) begin
            for (int f = 0; f <= 2; f++) begin
                wr(3'd0, 32'd1000);
                wr(3'd1, 32'd0);
                wr(3'd2, 32'd1 | (f << 8));
                wr(3'd0, rv);
                wr(3'd1, 32'd0);
                m = 0;
                while (!wd_event && m < 500) begin
                    @(negedge clk);
                    m++;
                end
                check_eq($sformatf("R2 latency rv=%0d", rv), m, rv + 1);
                w = 0;
                while (wd_event && w < 10000) begin
                    if (!rst_out) check_eq("R4 event inside reset", 0, 1);
                    @(negedge clk);
                    w++;
                end
                check_eq($sformatf("R4 width f=%0d", f), w, (f + 1) * 16);
                reset_len(r);
                check_eq("R5 tail after watchdog", r, 32'd2);
                rd(3'd3, d); check_eq("R6 watchdog cause", d, 32'd2);
                rd(3'd2, d); check_eq("R10 ctrl after reset", d, f << 8);
                rd(3'd0, d); check_eq("R10 reload kept", d, rv);
                wr(3'd3, 32'd2);
                rd(3'd3, d); check_eq("R7 clear by write", d, 32'd0);
            end
        end

        // R1 refresh keeps the reset away
        wr(3'd0, 32'd8);
        wr(3'd1, 32'd0);
        wr(3'd2, 32'd1);
        seen = 0;
        for (int k = 0; k < 30; k++) begin
            wr(3'd1, 32'd0);
            repeat (4) begin
                @(negedge clk);
                if (rst_out || wd_event) seen = 1;
            end
        end
        check_eq("R1 no reset while kicked", {31'd0, seen}, 32'd0);
        wr(3'd1, 32'd0);
        m = 0;
        while (!wd_event && m < 500) begin
            @(negedge clk);
            m++;
        end
        check_eq("R1 fires after kicks stop", m, 32'd9);
        reset_len(r);
        wr(3'd3, 32'd7);

        // R3 enable clear
        wr(3'd2, 32'd0);
        wr(3'd0, 32'd3);
        wr(3'd1, 32'd0);
        seen = 0;
        repeat (20) begin
            @(negedge clk);
            if (rst_out || wd_event) seen = 1;
        end
        check_eq("R3 no reset when disabled", {31'd0, seen}, 32'd0);
        rd(3'd1, d); check_eq("R3 count at zero", d, 32'd0);

        // R8 software reset
        for (int f = 0; f <= 3; f += 3) begin
            wr(3'd2, 32'd2 | (f << 8));
            seen = 0;
            r = 0;
            while (rst_out && r < 10000) begin
                if (wd_event) seen = 1;
                @(negedge clk);
                r++;
            end
            check_eq($sformatf("R8 sw reset length f=%0d", f), r, (f + 1) * 16 + 2);
            check_eq("R8 no host event", {31'd0, seen}, 32'd0);
            rd(3'd3, d); check_eq("R6 software cause", d, 32'd4);
        end

        // R9 R11 R6 hardware pin
        wr(3'd0, 32'd55);
        @(negedge clk);
        hw_rst_in = 1'b1;
        #1; check_eq("R5 async assert", {31'd0, rst_out}, 32'd1);
        for (int k = 0; k < 4; k++) begin
            boot_pins = 3'(k + 2);
            cfg_pins  = 5'(k * 7 + 1);
            @(negedge clk);
        end
        wr_en = 1'b1; addr = 3'd0; wdata = 32'h1234;
        @(negedge clk);
        wr_en = 1'b0;
        hw_rst_in = 1'b0;
        boot_pins = 3'd0;
        cfg_pins  = 5'd0;
        reset_len(r);
        check_eq("R5 tail after pin", r, 32'd2);
        rd(3'd4, d); check_eq("R9 strap captured", d, (32'd22 << 8) | 32'd5);
        rd(3'd3, d); check_eq("R6 causes accumulate", d, 32'd5);
        rd(3'd0, d); check_eq("R11 write blocked", d, 32'd55);
        boot_pins = 3'd7;
        cfg_pins  = 5'd31;
        repeat (3) @(negedge clk);
        rd(3'd4, d); check_eq("R9 strap holds", d, (32'd22 << 8) | 32'd5);
        wr(3'd3, 32'd1);
        rd(3'd3, d); check_eq("R7 partial clear", d, 32'd4);
        #1; check_eq("R12 rdata idle at end", rdata, 32'd0);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule